// File: doc/BRIEF.md
# Memory Responder with Conditional Swap

This block is a request/response front end for a small byte-addressable RAM held inside it. A requester presents one request at a time on a valid/ready handshake. Each request carries a command, a byte address, a power-of-two access size, write data, a compare value, a requestor ID and two qualifiers. One qualifier marks the request as already answered by a cache. The other says whether a response is wanted. The block decodes the command, touches the RAM, and returns a one-cycle response pulse with data when a response is wanted.

The swap commands do an indivisible read-modify-write. A swap hands back the old contents and stores the new data. A conditional swap stores the new data only when the old contents equal the supplied compare value. Both return the old contents in either case. While a swap is in progress the block holds its ready output low for exactly one cycle, so no other request can slip between the read and the write.

Store permission for plain writes comes from outside on an allow-store input. Some commands, such as cache-line evictions that carry no dirty data, are absorbed with no access and no response. Per-requestor counters record reads, stored writes, swap operations and bytes moved. A selector input reads these counters back.

Top module: `memrsp_top`

## Requirements
- R1: A request accepted with `reqCacheAnswered` high makes no RAM change and no response. It does not raise `errFlag` and it leaves every counter unchanged.
- R2: Command 5 (clean-evict) and command 6 (clean-writeback) make no RAM access, no response and no counter change, even when `reqNeedsResp` is high.
- R3: Command 0 (read) returns the accessed bytes in little-endian order, zero-extended to 64 bits, in `rspData`. `reqSize` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The response appears on the clock edge that accepts the request.
- R4: Command 1 (write) stores the bytes only while `allowStore` is high. The response data is 1 when the bytes were stored and 0 when they were not.
- R5: Command 2 (swap) returns the prior contents and stores the write data, whatever the level of `allowStore`. `reqReady` is low for exactly the one cycle after acceptance. The response appears one edge later than for a read.
- R6: Command 3 (conditional swap) compares the low 4 or 8 bytes of `reqCmp` with memory. It stores the write data only when they are equal. It returns the prior contents in either case and has the same timing as R5.
- R7: A conditional swap with a size of 1 or 2 bytes raises `errFlag`. It makes no RAM access and returns data 0.
- R8: A read, write, swap or conditional swap whose address is not a multiple of its size raises `errFlag`. It makes no RAM access and returns data 0.
- R9: Command 4 (invalidate/clean) leaves the RAM unchanged. It returns data 0 without error.
- R10: `rspValid` pulses only for requests accepted with `reqNeedsResp` high.
- R11: For each requestor, the counters advance by one read and the byte count for each good read. They advance by one write and the byte count for each stored write. They advance by one other-operation for each good swap or conditional swap. Errors, drops and refused writes are not counted.
- R12: Command 7 is reserved. It raises `errFlag` and makes no access.
- R13: After reset, the RAM and all counters are zero, `reqReady` is high, and `rspValid` and `errFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqCmd | input | 3 | Command code |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Log2 of access size in bytes |
| reqWdata | input | 64 | Write or swap data, little-endian |
| reqCmp | input | 64 | Compare value for conditional swap |
| reqId | input | ID_W | Requestor ID |
| reqCacheAnswered | input | 1 | Request already answered by a cache |
| reqNeedsResp | input | 1 | Requester wants a response |
| allowStore | input | 1 | Permission for plain writes |
| rspValid | output | 1 | Response pulse |
| rspData | output | 64 | Response data |
| errFlag | output | 1 | Error pulse, aligned with the response slot |
| cntSel | input | ID_W | Requestor whose counters are shown |
| cntReads | output | CNT_W | Reads by selected requestor |
| cntWrites | output | CNT_W | Stored writes by selected requestor |
| cntOther | output | CNT_W | Swap operations by selected requestor |
| cntBytesRd | output | CNT_W | Bytes read by selected requestor |
| cntBytesWr | output | CNT_W | Bytes written by selected requestor |

## Verification
Every result other than a swap's is registered on the edge that accepts the request. The bench therefore drives at a falling edge and waits for the accepting rising edge. It then samples `rspValid`, `rspData` and `errFlag` at the next falling edge. A good swap or conditional swap takes one extra edge. For these, the bench first checks at that falling edge that `reqReady` is low and no response is out. It then waits one more full cycle before sampling the response. The counter outputs are combinational. They are read at a falling edge after `cntSel` changes, and the RAM is read back through ordinary reads at the end.

// File: rtl/memrsp_pkg.sv
package memrsp_pkg;

  typedef enum logic [2:0] {
    CMD_READ    = 3'd0,
    CMD_WRITE   = 3'd1,
    CMD_SWAP    = 3'd2,
    CMD_CSWAP   = 3'd3,
    CMD_INVAL   = 3'd4,
    CMD_EVICT   = 3'd5,
    CMD_WBCLEAN = 3'd6,
    CMD_RSVD    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_DATA = 2'd1,
    RK_ACK  = 2'd2
  } rspKind_e;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic     hold;      // capture request fields for a swap
    logic     useHeld;   // operate on captured fields
    logic     memWr;     // write RAM (subject to condWr)
    logic     condWr;    // write only on compare match
    logic     rspEn;     // emit a response next edge
    logic     errEn;     // raise errFlag next edge
    rspKind_e rspKind;   // response data source
    logic     cntRead;
    logic     cntWrite;
    logic     cntOther;
  } strobe_t;

endpackage

// File: rtl/memrsp_ctrl.sv
module memrsp_ctrl
  import memrsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [2:0] reqCmd,
  input  logic [2:0] addrLow,
  input  logic [1:0] reqSize,
  input  logic       reqCacheAnswered,
  input  logic       reqNeedsResp,
  input  logic       allowStore,
  output strobe_t    stb
);

  typedef enum logic {ST_IDLE, ST_SWAP} state_e;

  state_e state, stateNxt;
  logic   heldCond, heldNeeds;
  logic   accept, misalign, cswapBadSize, reqBad;
  logic [2:0] alignMask;
  cmd_e   cmd;

  assign cmd      = cmd_e'(reqCmd);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady && !reqCacheAnswered;

  always_comb begin
    unique case (reqSize)
      2'd0:    alignMask = 3'b000;
      2'd1:    alignMask = 3'b001;
      2'd2:    alignMask = 3'b011;
      default: alignMask = 3'b111;
    endcase
  end

  assign misalign     = |(addrLow & alignMask);
  assign cswapBadSize = (cmd == CMD_CSWAP) && !reqSize[1];
  assign reqBad       = misalign || cswapBadSize;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    if (state == ST_SWAP) begin
      stb.useHeld  = 1'b1;
      stb.memWr    = 1'b1;
      stb.condWr   = heldCond;
      stb.rspEn    = heldNeeds;
      stb.rspKind  = RK_DATA;
      stb.cntOther = 1'b1;
      stateNxt     = ST_IDLE;
    end else if (accept) begin
      unique case (cmd)
        CMD_EVICT, CMD_WBCLEAN: ;
        CMD_INVAL: begin
          stb.rspEn = reqNeedsResp;
        end
        CMD_RSVD: begin
          stb.rspEn = reqNeedsResp;
          stb.errEn = 1'b1;
        end
        default: begin
          if (reqBad) begin
            stb.rspEn = reqNeedsResp;
            stb.errEn = 1'b1;
          end else if (cmd == CMD_READ) begin
            stb.rspEn   = reqNeedsResp;
            stb.rspKind = RK_DATA;
            stb.cntRead = 1'b1;
          end else if (cmd == CMD_WRITE) begin
            stb.memWr    = allowStore;
            stb.cntWrite = allowStore;
            stb.rspEn    = reqNeedsResp;
            stb.rspKind  = RK_ACK;
          end else begin
            stb.hold = 1'b1;
            stateNxt = ST_SWAP;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldCond  <= 1'b0;
      heldNeeds <= 1'b0;
    end else begin
      state <= stateNxt;
      if (stb.hold) begin
        heldCond  <= (cmd == CMD_CSWAP);
        heldNeeds <= reqNeedsResp;
      end
    end
  end

endmodule

// File: rtl/memrsp_dp.sv
module memrsp_dp
  import memrsp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  input  logic [63:0]       reqCmp,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ID_W-1:0]   cntSel,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              errFlag,
  output logic [CNT_W-1:0]  cntReads,
  output logic [CNT_W-1:0]  cntWrites,
  output logic [CNT_W-1:0]  cntOther,
  output logic [CNT_W-1:0]  cntBytesRd,
  output logic [CNT_W-1:0]  cntBytesWr
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NUM_REQ = 1 << ID_W;
  localparam int LANES   = 8;

  logic [7:0] mem [DEPTH];

  logic [ADDR_W-1:0] heldAddr, opAddr;
  logic [1:0]        heldSize, opSize;
  logic [63:0]       heldWdata, heldCmp, opWdata, opCmp;
  logic [ID_W-1:0]   heldId, opId;
  logic [3:0]        nBytes;
  logic [63:0]       oldVal, sizeMask;
  logic              cmpMatch, doWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldSize  <= '0;
      heldWdata <= '0;
      heldCmp   <= '0;
      heldId    <= '0;
    end else if (stb.hold) begin
      heldAddr  <= reqAddr;
      heldSize  <= reqSize;
      heldWdata <= reqWdata;
      heldCmp   <= reqCmp;
      heldId    <= reqId;
    end
  end

  assign opAddr  = stb.useHeld ? heldAddr  : reqAddr;
  assign opSize  = stb.useHeld ? heldSize  : reqSize;
  assign opWdata = stb.useHeld ? heldWdata : reqWdata;
  assign opCmp   = stb.useHeld ? heldCmp   : reqCmp;
  assign opId    = stb.useHeld ? heldId    : reqId;
  assign nBytes  = 4'd1 << opSize;

  // Gather the addressed bytes, little-endian, zero above the size
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (4'(i) < nBytes) begin
        oldVal[8*i +: 8]   = mem[opAddr + ADDR_W'(i)];
        sizeMask[8*i +: 8] = 8'hFF;
      end else begin
        oldVal[8*i +: 8]   = 8'h00;
        sizeMask[8*i +: 8] = 8'h00;
      end
    end
  end

  assign cmpMatch = ((oldVal ^ opCmp) & sizeMask) == 64'd0;
  assign doWrite  = stb.memWr && (!stb.condWr || cmpMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= 8'h00;
    end else if (doWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (4'(i) < nBytes) mem[opAddr + ADDR_W'(i)] <= opWdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      errFlag  <= 1'b0;
    end else begin
      rspValid <= stb.rspEn;
      errFlag  <= stb.errEn;
      unique case (stb.rspKind)
        RK_DATA: rspData <= oldVal;
        RK_ACK:  rspData <= {63'd0, stb.memWr};
        default: rspData <= 64'd0;
      endcase
    end
  end

  logic [CNT_W-1:0] rdCnt  [NUM_REQ];
  logic [CNT_W-1:0] wrCnt  [NUM_REQ];
  logic [CNT_W-1:0] othCnt [NUM_REQ];
  logic [CNT_W-1:0] rdByte [NUM_REQ];
  logic [CNT_W-1:0] wrByte [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_cnt
    logic [CNT_W-1:0] rdQ, wrQ, othQ, rdBQ, wrBQ;
    logic             hit;
    assign hit = (opId == ID_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdQ  <= '0;
        wrQ  <= '0;
        othQ <= '0;
        rdBQ <= '0;
        wrBQ <= '0;
      end else if (hit) begin
        if (stb.cntRead) begin
          rdQ  <= rdQ + CNT_W'(1);
          rdBQ <= rdBQ + CNT_W'(nBytes);
        end
        if (stb.cntWrite) begin
          wrQ  <= wrQ + CNT_W'(1);
          wrBQ <= wrBQ + CNT_W'(nBytes);
        end
        if (stb.cntOther) othQ <= othQ + CNT_W'(1);
      end
    end
    assign rdCnt[g]  = rdQ;
    assign wrCnt[g]  = wrQ;
    assign othCnt[g] = othQ;
    assign rdByte[g] = rdBQ;
    assign wrByte[g] = wrBQ;
  end

  assign cntReads   = rdCnt[cntSel];
  assign cntWrites  = wrCnt[cntSel];
  assign cntOther   = othCnt[cntSel];
  assign cntBytesRd = rdByte[cntSel];
  assign cntBytesWr = wrByte[cntSel];

endmodule

// File: rtl/memrsp_top.sv
module memrsp_top
  import memrsp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  input  logic [63:0]       reqCmp,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqCacheAnswered,
  input  logic              reqNeedsResp,
  input  logic              allowStore,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              errFlag,
  input  logic [ID_W-1:0]   cntSel,
  output logic [CNT_W-1:0]  cntReads,
  output logic [CNT_W-1:0]  cntWrites,
  output logic [CNT_W-1:0]  cntOther,
  output logic [CNT_W-1:0]  cntBytesRd,
  output logic [CNT_W-1:0]  cntBytesWr
);

  strobe_t stb;

  memrsp_ctrl u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .reqValid         (reqValid),
    .reqReady         (reqReady),
    .reqCmd           (reqCmd),
    .addrLow          (reqAddr[2:0]),
    .reqSize          (reqSize),
    .reqCacheAnswered (reqCacheAnswered),
    .reqNeedsResp     (reqNeedsResp),
    .allowStore       (allowStore),
    .stb              (stb)
  );

  memrsp_dp #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .reqCmp     (reqCmp),
    .reqId      (reqId),
    .cntSel     (cntSel),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .errFlag    (errFlag),
    .cntReads   (cntReads),
    .cntWrites  (cntWrites),
    .cntOther   (cntOther),
    .cntBytesRd (cntBytesRd),
    .cntBytesWr (cntBytesWr)
  );

endmodule

// File: rtl/memrsp_chk.sv
module memrsp_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [2:0]  reqCmd,
  input logic [2:0]  addrLow,
  input logic [1:0]  reqSize,
  input logic        reqCacheAnswered,
  input logic        reqNeedsResp,
  input logic        rspValid,
  input logic [63:0] rspData,
  input logic        errFlag
);

  logic accepted, live;
  assign accepted = reqValid && reqReady;
  assign live     = accepted && !reqCacheAnswered;

  // R1: an answered request leaves no trace in the next cycle
  a_r1_cache_drop: assert property (@(posedge clk) disable iff (!rstN)
    accepted && reqCacheAnswered |=> !rspValid && !errFlag && reqReady);

  // R2: eviction-type commands are silent
  a_r2_evict_silent: assert property (@(posedge clk) disable iff (!rstN)
    live && (reqCmd == 3'd5 || reqCmd == 3'd6) |=> !rspValid && !errFlag);

  // R5: a byte swap is always aligned, so it must stall for one cycle
  a_r5_swap_stall: assert property (@(posedge clk) disable iff (!rstN)
    live && reqCmd == 3'd2 && reqSize == 2'd0 |=> !reqReady && !rspValid);

  // R5: the stall never lasts beyond one cycle
  a_r5_one_stall: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  // R7: undersized conditional swap flags an error without stalling
  a_r7_cswap_size: assert property (@(posedge clk) disable iff (!rstN)
    live && reqCmd == 3'd3 && !reqSize[1] |=> errFlag && reqReady);

  // R8: odd address on a multi-byte read is an error with zero data
  a_r8_misalign: assert property (@(posedge clk) disable iff (!rstN)
    live && reqCmd == 3'd0 && reqSize != 2'd0 && addrLow[0] |=> errFlag && rspData == 64'd0);

  // R9: invalidate answers with zero and no error
  a_r9_inval: assert property (@(posedge clk) disable iff (!rstN)
    live && reqCmd == 3'd4 && reqNeedsResp |=> rspValid && rspData == 64'd0 && !errFlag);

  // R10: no response unless asked for (single-cycle commands)
  a_r10_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    live && !reqNeedsResp && (reqCmd == 3'd0 || reqCmd == 3'd1 || reqCmd == 3'd4) |=> !rspValid);

  // R12: reserved command flags an error
  a_r12_reserved: assert property (@(posedge clk) disable iff (!rstN)
    live && reqCmd == 3'd7 |=> errFlag);

endmodule

bind memrsp_top memrsp_chk u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .reqValid         (reqValid),
  .reqReady         (reqReady),
  .reqCmd           (reqCmd),
  .addrLow          (reqAddr[2:0]),
  .reqSize          (reqSize),
  .reqCacheAnswered (reqCacheAnswered),
  .reqNeedsResp     (reqNeedsResp),
  .rspValid         (rspValid),
  .rspData          (rspData),
  .errFlag          (errFlag)
);

// File: tb/memrsp_top_tb.sv
module memrsp_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int ID_W       = 2;
  localparam int CNT_W      = 16;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int NREQ       = 1 << ID_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [2:0]        reqCmd;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic [63:0]       reqWdata, reqCmp;
  logic [ID_W-1:0]   reqId;
  logic              reqCacheAnswered, reqNeedsResp, allowStore;
  logic              rspValid, errFlag;
  logic [63:0]       rspData;
  logic [ID_W-1:0]   cntSel;
  logic [CNT_W-1:0]  cntReads, cntWrites, cntOther, cntBytesRd, cntBytesWr;

  always #(CLK_PERIOD/2) clk = ~clk;

  memrsp_top #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_dut (.*);

  // Reference model state
  logic [7:0]  mdl [DEPTH];
  int unsigned mRd [NREQ];
  int unsigned mWr [NREQ];
  int unsigned mOth[NREQ];
  int unsigned mBRd[NREQ];
  int unsigned mBWr[NREQ];

  int nChk  = 0;
  int nFail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] peek(input logic [7:0] addr, input logic [1:0] size);
    logic [63:0] v = '0;
    int nb = 1 << size;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = mdl[8'(addr + 8'(i))];
    return v;
  endfunction

  function automatic logic [63:0] maskOf(input logic [1:0] size);
    logic [63:0] m = '0;
    int nb = 1 << size;
    for (int i = 0; i < nb; i++) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic poke(input logic [7:0] addr, input logic [1:0] size, input logic [63:0] d);
    int nb = 1 << size;
    for (int i = 0; i < nb; i++) mdl[8'(addr + 8'(i))] = d[8*i +: 8];
  endtask

  // Issue one request, update the model, check the response in its due cycle
  task automatic doReq(input logic [2:0] cmd, input logic [7:0] addr, input logic [1:0] size,
                       input logic [63:0] wd, input logic [63:0] cmp, input logic [1:0] id,
                       input bit cache, input bit needs, input bit allow);
    int          nb    = 1 << size;
    bit          misal = (int'(addr) % nb) != 0;
    logic [63:0] old   = peek(addr, size);
    bit          expV  = 0;
    bit          expE  = 0;
    bit          two   = 0;
    logic [63:0] expD  = '0;
    string       tag   = "R3";

    if (cache) begin
      tag = "R1";
    end else begin
      case (cmd)
        3'd0: begin
          tag = misal ? "R8" : "R3";
          if (misal) expE = 1;
          else begin
            expV = needs; expD = old; mRd[id]++; mBRd[id] += nb;
          end
        end
        3'd1: begin
          tag = misal ? "R8" : "R4";
          if (misal) expE = 1;
          else begin
            expV = needs; expD = {63'd0, allow};
            if (allow) begin poke(addr, size, wd); mWr[id]++; mBWr[id] += nb; end
          end
        end
        3'd2, 3'd3: begin
          tag = (cmd == 3'd2) ? "R5" : "R6";
          if (cmd == 3'd3 && size < 2) begin tag = "R7"; expE = 1; end
          else if (misal) begin tag = "R8"; expE = 1; end
          else begin
            two = 1; expV = needs; expD = old; mOth[id]++;
            if (cmd == 3'd2 || ((old ^ cmp) & maskOf(size)) == 64'd0) poke(addr, size, wd);
          end
        end
        3'd4: begin tag = "R9"; expV = needs; end
        3'd5, 3'd6: tag = "R2";
        default: begin tag = "R12"; expE = 1; end
      endcase
      if (expE) expV = needs;
    end

    @(negedge clk);
    reqCmd = cmd; reqAddr = addr; reqSize = size; reqWdata = wd; reqCmp = cmp;
    reqId = id; reqCacheAnswered = cache; reqNeedsResp = needs; allowStore = allow;
    reqValid = 1'b1;
    chk("R5 ready before request", 64'(reqReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (two) begin
      chk({tag, " ready low during swap"}, 64'(reqReady), 64'd0);
      chk({tag, " no early response"}, 64'(rspValid), 64'd0);
      @(posedge clk);
      @(negedge clk);
    end
    chk(needs ? {tag, " rspValid"} : {tag, " R10 rspValid"}, 64'(rspValid), 64'(expV));
    if (expV) chk({tag, " rspData"}, rspData, expD);
    chk({tag, " errFlag"}, 64'(errFlag), 64'(expE));
  endtask

  // R11: compare every requestor's counters with the model
  task automatic chkCounters();
    for (int r = 0; r < NREQ; r++) begin
      @(negedge clk);
      cntSel = ID_W'(r);
      #1;
      chk("R11 reads",   64'(cntReads),   64'(CNT_W'(mRd[r])));
      chk("R11 writes",  64'(cntWrites),  64'(CNT_W'(mWr[r])));
      chk("R11 other",   64'(cntOther),   64'(CNT_W'(mOth[r])));
      chk("R11 bytesRd", 64'(cntBytesRd), 64'(CNT_W'(mBRd[r])));
      chk("R11 bytesWr", 64'(cntBytesWr), 64'(CNT_W'(mBWr[r])));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'h5EED1);
    for (int k = 0; k < DEPTH; k++) mdl[k] = 8'h00;
    for (int r = 0; r < NREQ; r++) begin
      mRd[r] = 0; mWr[r] = 0; mOth[r] = 0; mBRd[r] = 0; mBWr[r] = 0;
    end
    rstN = 1'b0; reqValid = 1'b0; reqCmd = '0; reqAddr = '0; reqSize = '0;
    reqWdata = '0; reqCmp = '0; reqId = '0; reqCacheAnswered = 1'b0;
    reqNeedsResp = 1'b0; allowStore = 1'b0; cntSel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R13: reset state
    chk("R13 ready", 64'(reqReady), 64'd1);
    chk("R13 rspValid", 64'(rspValid), 64'd0);
    chk("R13 errFlag", 64'(errFlag), 64'd0);
    chkCounters();
    doReq(3'd0, 8'h40, 2'd3, 64'd0, 64'd0, 2'd0, 0, 1, 1);          // R13 RAM zero

    // R3 / R4: write then read at every size
    doReq(3'd1, 8'h10, 2'd3, 64'h8877665544332211, 64'd0, 2'd1, 0, 1, 1);
    doReq(3'd0, 8'h10, 2'd0, 64'd0, 64'd0, 2'd1, 0, 1, 1);
    doReq(3'd0, 8'h12, 2'd1, 64'd0, 64'd0, 2'd1, 0, 1, 1);
    doReq(3'd0, 8'h14, 2'd2, 64'd0, 64'd0, 2'd1, 0, 1, 1);
    doReq(3'd1, 8'h10, 2'd2, 64'hDEADBEEF, 64'd0, 2'd1, 0, 1, 0);    // R4 refused
    doReq(3'd0, 8'h10, 2'd3, 64'd0, 64'd0, 2'd1, 0, 1, 1);
    // R5: swap ignores allowStore
    doReq(3'd2, 8'h10, 2'd2, 64'hCAFEF00D, 64'd0, 2'd2, 0, 1, 0);
    doReq(3'd0, 8'h10, 2'd2, 64'd0, 64'd0, 2'd2, 0, 1, 1);
    // R6: conditional swap match / mismatch, 4 and 8 bytes
    doReq(3'd3, 8'h10, 2'd2, 64'h11112222, 64'hFFFF_FFFF_CAFEF00D, 2'd3, 0, 1, 1);
    doReq(3'd3, 8'h10, 2'd2, 64'h33334444, 64'h0000_0000_12345678, 2'd3, 0, 1, 1);
    doReq(3'd3, 8'h10, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, peek(8'h10, 2'd3), 2'd3, 0, 1, 1);
    doReq(3'd0, 8'h10, 2'd3, 64'd0, 64'd0, 2'd3, 0, 1, 1);
    // R7, R8, R12: errors
    doReq(3'd3, 8'h20, 2'd1, 64'h5555, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd0, 8'h11, 2'd2, 64'd0, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd1, 8'h13, 2'd1, 64'h7777, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd7, 8'h00, 2'd0, 64'd0, 64'd0, 2'd0, 0, 1, 1);
    // R9, R2, R1, R10
    doReq(3'd4, 8'h10, 2'd3, 64'd0, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd5, 8'h10, 2'd3, 64'h99, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd6, 8'h10, 2'd3, 64'h99, 64'd0, 2'd0, 0, 1, 1);
    doReq(3'd1, 8'h10, 2'd3, 64'h99, 64'd0, 2'd0, 1, 1, 1);
    doReq(3'd0, 8'h10, 2'd3, 64'd0, 64'd0, 2'd0, 0, 0, 1);
    doReq(3'd0, 8'h10, 2'd3, 64'd0, 64'd0, 2'd0, 0, 1, 1);
    chkCounters();

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  cmd   = 3'($urandom % 8);
      logic [1:0]  size  = 2'($urandom % 4);
      logic [7:0]  addr  = 8'($urandom % 64);
      logic [63:0] wd    = {$urandom, $urandom};
      logic [63:0] cmp   = {$urandom, $urandom};
      logic [1:0]  id    = 2'($urandom % 4);
      bit          cache = ($urandom % 16) == 0;
      bit          needs = ($urandom % 4) != 0;
      bit          allow = ($urandom % 4) != 0;
      if (($urandom % 8) != 0) addr = addr & ~8'((1 << size) - 1);
      if (($urandom % 2) == 0) cmp = peek(addr, size);
      doReq(cmd, addr, size, wd, cmp, id, cache, needs, allow);
    end
    chkCounters();

    // Final RAM sweep through reads
    for (int a = 0; a < 64; a += 8) doReq(3'd0, 8'(a), 2'd3, 64'd0, 64'd0, 2'd0, 0, 1, 1);
    chkCounters();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule